// File: doc/BRIEF.md
# Read Latency and Data Mask Pipeline

This block sits on the data path between a synchronous DRAM array, or a controller's model of one, and the DQ pins. Read beats leave the array with a valid strobe. The block holds each beat back by the programmed read latency and then drives it onto the data bus for one clock with the output enable raised. The latency is either two or three clocks.

The block applies the data mask pin with a different lag in each direction. On writes the mask acts in the same cycle and suppresses the per-beat array write enable. On reads the mask blanks the output two clocks after it is sampled. A precharge or burst-stop event cancels the beat sampled with it, so the bus returns to high impedance one read latency after the event.

The latency setting is only adopted once the pipeline is empty. Every beat is therefore delivered with the latency that was in force when it was sampled. All inputs are sampled on the rising clock edge, and the read-side outputs are registered.

Top module: `cas_read_pipe`

## Requirements
- R1: Asynchronous active-low reset clears the bus (`dqOe` low, `dqOut` zero) and the mask history, and selects latency 2. A read sampled at the first edge after reset appears two edges later, even when `latSel` is 1.
- R2: Latency is selected by `latSel`: 0 means 2 clocks and 1 means 3 clocks. A read beat sampled at rising edge n with latency L is driven after edge n+L for exactly one clock, with `dqOe` high and `dqOut` equal to its `rdData`.
- R3: In any cycle without a scheduled beat, `dqOe` is low and `dqOut` is all zeros.
- R4: `dqm` sampled high at edge m blanks the output after edge m+2. `dqOe` is low and `dqOut` is zero there. No other beat moves or changes.
- R5: `wrEn` equals `wrValid` and not `dqm` in the same cycle. `wrDataOut` equals `wrData` unchanged.
- R6: `prechg` or `burstStop` high at edge p discards the read beat sampled at edge p. Beats sampled before p are still delivered, so the bus is idle after edge p+L unless later beats arrive. The two events behave identically.
- R7: `latSel` is adopted only at an edge where no beat is in flight and `rdValid` is low. A change made while a burst is in flight therefore leaves that burst, and any beat sampled before the adoption, on the old latency.
- R8: Beats sampled on consecutive edges come out on consecutive cycles with no gap and in order, at both latencies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| latSel | input | 1 | Requested read latency: 0 for 2 clocks, 1 for 3 clocks |
| rdValid | input | 1 | A read beat is presented on rdData this cycle |
| rdData | input | DW | Read data from the array |
| prechg | input | 1 | Precharge event that cuts the read |
| burstStop | input | 1 | Burst-stop event that cuts the read |
| dqm | input | 1 | Data mask pin |
| wrValid | input | 1 | A write beat is on wrData this cycle |
| wrData | input | DW | Write data from the DQ pins |
| dqOe | output | 1 | Output enable for the DQ drivers |
| dqOut | output | DW | Read data driven to the DQ pins |
| wrEn | output | 1 | Per-beat array write enable after masking |
| wrDataOut | output | DW | Write data toward the array |

## Verification
A wrong entry slot or a stale latency register shows up on the very next read. The beat appears one cycle early or late, and any gap in a back-to-back burst exposes a broken shift chain. A mask history that is one stage too short or too long blanks a neighbouring beat instead of the intended one. This becomes visible two to three cycles after the mask pulse. A termination that is gated in the wrong place either leaks the cancelled beat onto the bus L cycles later or swallows earlier beats. Sweeping every termination position across a burst at both latencies reveals either fault within one burst.

// File: rtl/cas_pipe_pkg.sv
package cas_pipe_pkg;
  localparam int MIN_LAT   = 2;
  localparam int MAX_LAT   = 3;
  localparam int LAT_SEL_W = 1;
  localparam int STAGES    = MAX_LAT;
  localparam int DQZ_DLY   = 2;

  typedef struct packed {
    logic [STAGES-1:0] loadSlot;
    logic              blankOut;
  } pipe_ctl_t;
endpackage

// File: rtl/cas_pipe_ctrl.sv
module cas_pipe_ctrl
  import cas_pipe_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LAT_SEL_W-1:0] latSel,
  input  logic                 rdValid,
  input  logic                 prechg,
  input  logic                 burstStop,
  input  logic                 dqm,
  input  logic                 inFlight,
  output pipe_ctl_t            ctl
);
  logic [LAT_SEL_W-1:0] latCode;
  logic [DQZ_DLY-1:0]   dqmHist;
  logic                 accept;

  // Latency is adopted only with an empty pipe and no beat arriving
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     latCode <= '0;
    else if (!inFlight && !rdValid) latCode <= latSel;
  end

  generate
    if (DQZ_DLY == 1) begin : g_dqm1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) dqmHist <= '0;
        else       dqmHist <= dqm;
      end
    end else begin : g_dqmN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) dqmHist <= '0;
        else       dqmHist <= {dqmHist[DQZ_DLY-2:0], dqm};
      end
    end
  endgenerate

  assign accept = rdValid && !(prechg || burstStop);

  // Entry slot: latency L enters at stage MAX_LAT-L
  always_comb begin
    ctl.loadSlot = '0;
    for (int i = 0; i < STAGES; i++) begin
      if (accept && (int'(latCode) == MAX_LAT - MIN_LAT - i))
        ctl.loadSlot[i] = 1'b1;
    end
    ctl.blankOut = dqmHist[DQZ_DLY-1];
  end
endmodule

// File: rtl/cas_pipe_data.sv
module cas_pipe_data
  import cas_pipe_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  pipe_ctl_t     ctl,
  input  logic [DW-1:0] rdData,
  input  logic          dqm,
  input  logic          wrValid,
  input  logic [DW-1:0] wrData,
  output logic          inFlight,
  output logic          dqOe,
  output logic [DW-1:0] dqOut,
  output logic          wrEn,
  output logic [DW-1:0] wrDataOut
);
  logic [STAGES-1:0]         sVal;
  logic [STAGES-1:0][DW-1:0] sDat;
  logic [STAGES-1:0][DW-1:0] shDat;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_feed
      if (i == 0) begin : g_head
        assign shDat[i] = '0;
      end else begin : g_body
        assign shDat[i] = sDat[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sVal <= '0;
      sDat <= '0;
    end else begin
      sVal <= ({sVal[STAGES-2:0], 1'b0} & ~ctl.loadSlot) | ctl.loadSlot;
      for (int i = 0; i < STAGES; i++)
        sDat[i] <= ctl.loadSlot[i] ? rdData : shDat[i];
    end
  end

  assign inFlight = |sVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqOe  <= 1'b0;
      dqOut <= '0;
    end else begin
      dqOe  <= sVal[STAGES-1] && !ctl.blankOut;
      dqOut <= (sVal[STAGES-1] && !ctl.blankOut) ? sDat[STAGES-1] : '0;
    end
  end

  assign wrEn      = wrValid && !dqm;
  assign wrDataOut = wrData;
endmodule

// File: rtl/cas_read_pipe.sv
module cas_read_pipe
  import cas_pipe_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LAT_SEL_W-1:0] latSel,
  input  logic                 rdValid,
  input  logic [DW-1:0]        rdData,
  input  logic                 prechg,
  input  logic                 burstStop,
  input  logic                 dqm,
  input  logic                 wrValid,
  input  logic [DW-1:0]        wrData,
  output logic                 dqOe,
  output logic [DW-1:0]        dqOut,
  output logic                 wrEn,
  output logic [DW-1:0]        wrDataOut
);
  pipe_ctl_t ctl;
  logic      inFlight;

  cas_pipe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .latSel(latSel), .rdValid(rdValid),
    .prechg(prechg), .burstStop(burstStop), .dqm(dqm),
    .inFlight(inFlight), .ctl(ctl)
  );

  cas_pipe_data #(.DW(DW)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdData(rdData), .dqm(dqm),
    .wrValid(wrValid), .wrData(wrData), .inFlight(inFlight),
    .dqOe(dqOe), .dqOut(dqOut), .wrEn(wrEn), .wrDataOut(wrDataOut)
  );
endmodule

// File: rtl/cas_pipe_chk.sv
module cas_pipe_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          rdValid,
  input logic          dqm,
  input logic          dqOe,
  input logic [DW-1:0] dqOut,
  input logic          wrEn
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R2: a driven beat was sampled two or three edges before its output edge
  a_r2_beat_source: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 3'd5 && dqOe) |-> ($past(rdValid, 3) || $past(rdValid, 4)));

  // R3: idle bus carries zeros
  a_r3_idle_bus: assert property (@(posedge clk) disable iff (!rstN)
    !dqOe |-> (dqOut == '0));

  // R4: mask on a read blanks the output two edges later
  a_r4_dqm_blank: assert property (@(posedge clk) disable iff (!rstN)
    dqm |-> ##3 !dqOe);

  // R5: mask on a write suppresses the array write in the same cycle
  a_r5_write_mask: assert property (@(posedge clk) disable iff (!rstN)
    dqm |-> !wrEn);
endmodule

bind cas_read_pipe cas_pipe_chk #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .rdValid(rdValid), .dqm(dqm),
  .dqOe(dqOe), .dqOut(dqOut), .wrEn(wrEn)
);

// File: tb/cas_read_pipe_tb.sv
module cas_read_pipe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int HIST = 8192;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [0:0]    latSel = 1'b0;
  logic          rdValid = 1'b0;
  logic [DW-1:0] rdData = '0;
  logic          prechg = 1'b0;
  logic          burstStop = 1'b0;
  logic          dqm = 1'b0;
  logic          wrValid = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          dqOe;
  logic [DW-1:0] dqOut;
  logic          wrEn;
  logic [DW-1:0] wrDataOut;

  cas_read_pipe #(.DW(DW)) u_dut (
    .clk(clk), .rstN(rstN), .latSel(latSel), .rdValid(rdValid), .rdData(rdData),
    .prechg(prechg), .burstStop(burstStop), .dqm(dqm), .wrValid(wrValid),
    .wrData(wrData), .dqOe(dqOe), .dqOut(dqOut), .wrEn(wrEn), .wrDataOut(wrDataOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";
  bit started = 0;
  int edgeNo = 0;
  int lastEdge = 0;
  int mLat = 2;
  bit bt [HIST];
  logic [DW-1:0] bd [HIST];
  bit dqH [HIST];
  logic [DW-1:0] dseq = 8'h11;

  // Reference model, evaluated on the same edge the design samples
  always @(posedge clk) begin
    if (rstN) begin
      bit busy;
      busy = 1'b0;
      for (int t = 0; t <= 4; t++) if (bt[edgeNo + t]) busy = 1'b1;
      checks++;
      if (wrEn !== (wrValid && !dqm) || wrDataOut !== wrData) begin
        fails++;
        $display("FAIL R5 edge %0d: wrEn=%0b wrDataOut=%0h expected wrEn=%0b wrDataOut=%0h",
                 edgeNo, wrEn, wrDataOut, wrValid && !dqm, wrData);
      end
      if (rdValid && !(prechg || burstStop)) begin
        bt[edgeNo + mLat] = 1'b1;
        bd[edgeNo + mLat] = rdData;
      end
      dqH[edgeNo] = dqm;
      if (!busy && !rdValid) mLat = latSel ? 3 : 2;
      lastEdge = edgeNo;
      edgeNo++;
      started = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rstN && started) begin
      bit eOe;
      logic [DW-1:0] eDat;
      eOe  = bt[lastEdge] && !(lastEdge >= 2 && dqH[lastEdge-2]);
      eDat = eOe ? bd[lastEdge] : '0;
      checks++;
      if (dqOe !== eOe || dqOut !== eDat) begin
        fails++;
        $display("FAIL %s edge %0d: dqOe=%0b dqOut=%0h expected dqOe=%0b dqOut=%0h",
                 tag, lastEdge, dqOe, dqOut, eOe, eDat);
      end
    end
  end

  task automatic cyc(input bit rv, input bit dm, input bit pc, input bit bs);
    @(negedge clk);
    rdValid = rv; dqm = dm; prechg = pc; burstStop = bs;
    rdData = dseq;
    wrValid = dseq[1];
    wrData = dseq ^ 8'h5A;
    dseq = dseq + 8'd13;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1: bus quiet in reset; latSel=1 pending but first read uses latency 2
    latSel = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (dqOe !== 1'b0 || dqOut !== '0) begin
      fails++;
      $display("FAIL R1 reset: dqOe=%0b dqOut=%0h expected dqOe=0 dqOut=0", dqOe, dqOut);
    end
    rdValid = 1'b1; rdData = 8'hA5;
    rstN = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    idle(6);

    // R2/R3: every 5-beat issue pattern at both latencies
    tag = "R2";
    for (int ls = 0; ls < 2; ls++) begin
      latSel = ls[0];
      idle(5);
      for (int pat = 0; pat < 32; pat++) begin
        for (int b = 0; b < 5; b++) cyc(pat[b], 1'b0, 1'b0, 1'b0);
        tag = "R3"; idle(5); tag = "R2";
      end
    end

    // R8: long back-to-back bursts
    tag = "R8";
    for (int ls = 0; ls < 2; ls++) begin
      latSel = ls[0]; idle(5);
      for (int b = 0; b < 12; b++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
      idle(5);
    end

    // R4: one-cycle mask pulse at every position across a burst
    tag = "R4";
    for (int ls = 0; ls < 2; ls++) begin
      latSel = ls[0]; idle(5);
      for (int off = 0; off < 8; off++) begin
        for (int b = 0; b < 8; b++) cyc(b < 6, b == off, 1'b0, 1'b0);
        idle(5);
      end
    end

    // R6: termination at every burst position, both event inputs
    tag = "R6";
    for (int ls = 0; ls < 2; ls++) begin
      latSel = ls[0]; idle(5);
      for (int which = 0; which < 2; which++) begin
        for (int p = 0; p < 6; p++) begin
          for (int b = 0; b < 6; b++)
            cyc(1'b1, 1'b0, (b == p) && which == 0, (b == p) && which == 1);
          idle(5);
        end
      end
    end

    // R7: latency change while in flight is deferred
    tag = "R7";
    latSel = 1'b0; idle(5);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    latSel = 1'b1;
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    idle(6);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    latSel = 1'b0;
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    idle(6);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    idle(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule